// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Decoder

This block is the cycle decoder and storage core of a synchronous burst SRAM. On every rising clock edge it samples three chip selects, two address strobes (a processor-side strobe and a controller-side strobe), an advance input, a global write, a byte-write enable and four per-lane write enables. From these it classifies the cycle as a deselect, a burst start for a read, a burst start for a write, a burst continuation, or a burst suspension.

A control unit turns that classification into a small bundle of strobes: load, advance, read, and four lane write enables. A datapath uses the strobes to run a two-bit burst sequencer, in linear or interleaved order. It writes the selected byte lanes of a behavioural array in the decode cycle and returns read words through a drive token.

The read path has a one-stage flow-through mode and a two-stage pipelined mode. The drive token travels through the same stages as the data, so a deselect or a write ends the drive with the same latency a read takes to start it. A sleep input turns every cycle into a deselect and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset `rdValid` is 0, `rdData` is 0, no burst is active, and every array word reads as 0.
- R2: The chip counts as selected only when `selAN`=0, `selB`=1 and `selCN`=0. A cycle whose effective strobe finds the chip unselected, or in which `ctlStrobeN`=0 while `selAN`=1, is a deselect: it writes nothing, starts no drive and ends any active burst.
- R3: When `cpuStrobeN`=0 and `selAN`=0, a selected chip starts a read burst at `addrIn`. All write inputs are ignored in that cycle. When `selAN`=1, `cpuStrobeN` has no effect.
- R4: When `ctlStrobeN`=0 and the processor strobe is not in effect, a selected chip starts a burst at `addrIn`. The burst is a write when the write condition holds and a read otherwise.
- R5: The write condition holds when `globalWrN`=0, which writes all four lanes whatever the other write inputs are. It also holds when `byteWrN`=0 and at least one bit of `laneWrN` is 0; only those lanes are written. Lane k is `wrData[8k+7:8k]` and is enabled by `laneWrN[k]`.
- R6: With both strobes high during an active burst, `advN`=0 moves to the next burst address and `advN`=1 reuses the current one. Each such cycle is a write or a read according to the write condition sampled in that cycle.
- R7: The low two address bits of burst step c (c = 0..3, modulo 4) equal start+c with `burstLinear`=1 and start XOR c with `burstLinear`=0. The upper bits stay fixed, so the fifth address equals the first.
- R8: A cycle with both strobes high and no active burst is a deselect.
- R9: While `sleep`=1 every cycle is a deselect. Nothing is written and the array keeps its contents.
- R10: With `pipeMode`=0, the read word and `rdValid` of a cycle appear after that cycle's edge. With `pipeMode`=1 they appear one edge later. Deselect and write cycles drop `rdValid` with the same latency.
- R11: `rdData` is 0 whenever `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| selAN | input | 1 | Primary chip select, active low; also masks the processor strobe |
| selB | input | 1 | Secondary chip select, active high |
| selCN | input | 1 | Secondary chip select, active low |
| cpuStrobeN | input | 1 | Processor address strobe, active low; read-only start |
| ctlStrobeN | input | 1 | Controller address strobe, active low; read or write start |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Per-lane write qualifier, active low |
| laneWrN | input | 4 | Per-lane write enables, active low |
| burstLinear | input | 1 | 1 = linear burst order, 0 = interleaved |
| pipeMode | input | 1 | 1 = two-stage read path, 0 = one-stage |
| sleep | input | 1 | Low-power request; forces deselect |
| addrIn | input | ADDR_W | Word address for burst starts |
| wrData | input | 32 | Write data, four 8-bit lanes |
| rdData | output | 32 | Read word, 0 when not driven |
| rdValid | output | 1 | Drive token of the output stage |

## Verification
Two things can happen in the same cycle: a burst continuation decided by `advN`, and the start of a new burst through a strobe that may be masked. The bench provokes this with `cpuStrobeN` low while `selAN` is high during an active burst, and with both strobes low together. The bench's reference model judges the result by the address the burst uses next and by whether a write was applied, which it confirms later by reading those words back. Write and read per cycle collide in the same way for continue cycles: random write inputs flip them, and read-back checks each lane.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int NUM_LANES = 4;

  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_BEGIN_RD = 3'd1,
    CYC_BEGIN_WR = 3'd2,
    CYC_CONT     = 3'd3,
    CYC_SUSP     = 3'd4
  } cycKind_e;

  typedef struct packed {
    logic                 load;
    logic                 advance;
    logic                 readOp;
    logic [NUM_LANES-1:0] laneWe;
  } seqStrobes_t;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selAN,
  input  logic                 selB,
  input  logic                 selCN,
  input  logic                 cpuStrobeN,
  input  logic                 ctlStrobeN,
  input  logic                 advN,
  input  logic                 globalWrN,
  input  logic                 byteWrN,
  input  logic [NUM_LANES-1:0] laneWrN,
  input  logic                 sleep,
  output seqStrobes_t          strobes,
  output cycKind_e             kind,
  output logic                 burstActive
);
  logic                 chipSel;
  logic                 cpuGo;
  logic                 ctlGo;
  logic [NUM_LANES-1:0] laneReq;
  logic                 wrCond;
  logic                 midBurst;

  always_comb begin
    chipSel = !selAN && selB && !selCN;
    cpuGo   = !cpuStrobeN && !selAN;
    ctlGo   = !ctlStrobeN && !cpuGo;
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrN)   laneReq = ~laneWrN;
    else                 laneReq = '0;
    wrCond = |laneReq;

    kind = CYC_DESEL;
    if (sleep)            kind = CYC_DESEL;
    else if (cpuGo)       kind = chipSel ? CYC_BEGIN_RD : CYC_DESEL;
    else if (ctlGo)       kind = chipSel ? (wrCond ? CYC_BEGIN_WR : CYC_BEGIN_RD) : CYC_DESEL;
    else if (burstActive) kind = advN ? CYC_SUSP : CYC_CONT;

    midBurst        = (kind == CYC_CONT) || (kind == CYC_SUSP);
    strobes.load    = (kind == CYC_BEGIN_RD) || (kind == CYC_BEGIN_WR);
    strobes.advance = (kind == CYC_CONT);
    strobes.readOp  = (kind == CYC_BEGIN_RD) || (midBurst && !wrCond);
    strobes.laneWe  = ((kind == CYC_BEGIN_WR) || (midBurst && wrCond)) ? laneReq : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    burstActive <= 1'b0;
    else if (kind == CYC_DESEL)   burstActive <= 1'b0;
    else if (strobes.load)        burstActive <= 1'b1;
  end
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              burstLinear,
  input  logic              pipeMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / NUM_LANES;
  localparam int HI_W   = ADDR_W - 2;

  logic [HI_W-1:0]   baseHi;
  logic [1:0]        startLo;
  logic [1:0]        stepCnt;
  logic [1:0]        useCnt;
  logic [1:0]        effLo;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] rdWord;
  logic              valid1, valid2;
  logic [DATA_W-1:0] data1, data2;

  // burst sequencer
  always_comb begin
    useCnt  = strobes.advance ? stepCnt + 2'd1 : stepCnt;
    effLo   = burstLinear ? startLo + useCnt : startLo ^ useCnt;
    effAddr = strobes.load ? addrIn : {baseHi, effLo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi  <= '0;
      startLo <= '0;
      stepCnt <= '0;
    end else if (strobes.load) begin
      baseHi  <= addrIn[ADDR_W-1:2];
      startLo <= addrIn[1:0];
      stepCnt <= '0;
    end else if (strobes.advance) begin
      stepCnt <= useCnt;
    end
  end

  // byte-lane storage
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strobes.laneWe[g]) begin
        laneMem[effAddr] <= wrData[g*LANE_W +: LANE_W];
      end
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[effAddr];
  end

  // output stage, token and data share the stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
      data1  <= '0;
      data2  <= '0;
    end else begin
      valid1 <= strobes.readOp;
      data1  <= strobes.readOp ? rdWord : '0;
      valid2 <= valid1;
      data2  <= data1;
    end
  end

  assign rdValid = pipeMode ? valid2 : valid1;
  assign rdData  = pipeMode ? data2  : data1;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              cpuStrobeN,
  input  logic              ctlStrobeN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [3:0]        laneWrN,
  input  logic              burstLinear,
  input  logic              pipeMode,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  seqStrobes_t ctlBus;
  cycKind_e    cycKind;
  logic        burstActive;

  bsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
    .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneWrN(laneWrN), .sleep(sleep),
    .strobes(ctlBus), .kind(cycKind), .burstActive(burstActive)
  );

  bsr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(ctlBus), .burstLinear(burstLinear),
    .pipeMode(pipeMode), .addrIn(addrIn), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/sync_burst_sram_checker.sv
module sync_burst_sram_checker #(
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              pipeMode,
  input logic              selAN,
  input logic              selB,
  input logic              selCN,
  input logic              cpuStrobeN,
  input logic              ctlStrobeN,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [3:0]        laneWe,
  input logic              burstActive
);
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (laneWe == 4'b0000)); // R9

  AST_SLEEP_FLOW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && sleep) |=> (pipeMode || !rdValid)); // R9

  AST_CPU_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuStrobeN && !selAN) |-> (laneWe == 4'b0000)); // R3

  AST_MASKED_CTL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !ctlStrobeN && selAN && !pipeMode) |=> (pipeMode || !rdValid)); // R2

  AST_ORPHAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStrobeN && ctlStrobeN && !burstActive) |-> (laneWe == 4'b0000)); // R8

  AST_FLOW_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && !sleep && !cpuStrobeN && !selAN && selB && !selCN) |=> (pipeMode || rdValid)); // R10

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0)); // R11
endmodule

bind sync_burst_sram sync_burst_sram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .pipeMode(pipeMode),
  .selAN(selAN), .selB(selB), .selCN(selCN),
  .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN),
  .rdValid(rdValid), .rdData(rdData),
  .laneWe(ctlBus.laneWe), .burstActive(burstActive)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selAN = 1'b0, selB = 1'b1, selCN = 1'b0;
  logic cpuStrobeN = 1'b1, ctlStrobeN = 1'b1, advN = 1'b1;
  logic globalWrN = 1'b1, byteWrN = 1'b1;
  logic [3:0] laneWrN = 4'hF;
  logic burstLinear = 1'b1, pipeMode = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rdValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
    .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .pipeMode(pipeMode), .sleep(sleep),
    .addrIn(addrIn), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // reference model state
  logic [7:0]    mdlMem [4][DEPTH];
  logic          mdlActive;
  logic [AW-3:0] mdlHi;
  logic [1:0]    mdlStart, mdlCnt;
  logic          v1, v2;
  logic [31:0]   d1, d2;
  string         t1, t2;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mdlReset();
    for (int a = 0; a < DEPTH; a++)
      for (int l = 0; l < 4; l++) mdlMem[l][a] = 8'h00;
    mdlActive = 0; mdlHi = '0; mdlStart = 0; mdlCnt = 0;
    v1 = 0; v2 = 0; d1 = 0; d2 = 0; t1 = "R1"; t2 = "R1";
  endtask

  // one clock cycle: model prediction, edge, compare
  task automatic doCycle(input string tagOvr);
    logic sel, cpuGo, ctlGo, midB, wr, rd, ld, adv;
    logic [3:0] lanes;
    logic [1:0] cnt, lo;
    logic [AW-1:0] ea;
    logic [31:0] word;
    string tag;
    sel   = !selAN && selB && !selCN;           // R2
    cpuGo = !cpuStrobeN && !selAN;              // R3
    ctlGo = !ctlStrobeN && !cpuGo;              // R4
    lanes = !globalWrN ? 4'hF : (!byteWrN ? ~laneWrN : 4'h0); // R5
    ld = 0; adv = 0; rd = 0; wr = 0; midB = 0; tag = "R2";
    if (sleep) tag = "R9";
    else if (cpuGo) begin
      if (sel) begin ld = 1; rd = 1; tag = "R3"; end
    end else if (ctlGo) begin
      if (sel) begin ld = 1; rd = (lanes == 0); wr = !rd; tag = "R4"; end
    end else if (mdlActive) begin
      midB = 1; adv = !advN; rd = (lanes == 0); wr = !rd; tag = "R6";
    end else tag = "R8";
    cnt = adv ? mdlCnt + 2'd1 : mdlCnt;
    lo  = burstLinear ? mdlStart + cnt : mdlStart ^ cnt;   // R7
    ea  = ld ? addrIn : {mdlHi, lo};
    word = {mdlMem[3][ea], mdlMem[2][ea], mdlMem[1][ea], mdlMem[0][ea]};
    if (tagOvr != "") tag = tagOvr;
    @(posedge clk);
    if (wr) for (int l = 0; l < 4; l++) if (lanes[l]) mdlMem[l][ea] = wrData[l*8 +: 8];
    if (ld) begin mdlHi = addrIn[AW-1:2]; mdlStart = addrIn[1:0]; mdlCnt = 0; mdlActive = 1; end
    else if (adv) mdlCnt = cnt;
    if (!ld && !midB) mdlActive = 0;
    v2 = v1; d2 = d1; t2 = t1;
    v1 = rd; d1 = rd ? word : 32'h0; t1 = tag;
    @(negedge clk);
    if (pipeMode) begin
      check({t2, " R10 valid"}, {31'b0, rdValid}, {31'b0, v2});
      check({t2, " R11 data"}, rdData, d2);
    end else begin
      check({t1, " valid"}, {31'b0, rdValid}, {31'b0, v1});
      check({t1, " R11 data"}, rdData, d1);
    end
  endtask

  task automatic idle();
    selAN = 0; selB = 1; selCN = 0; cpuStrobeN = 1; ctlStrobeN = 1; advN = 1;
    globalWrN = 1; byteWrN = 1; laneWrN = 4'hF; sleep = 0;
  endtask

  task automatic ctlCmd(input logic [AW-1:0] a, input logic gw, input logic bw,
                        input logic [3:0] ln, input logic [31:0] d, input string tag);
    idle(); ctlStrobeN = 0; addrIn = a; globalWrN = gw; byteWrN = bw; laneWrN = ln; wrData = d;
    doCycle(tag);
  endtask

  task automatic burstRead(input logic [AW-1:0] a, input string tag);
    ctlCmd(a, 1, 1, 4'hF, 0, tag);
    for (int i = 0; i < 4; i++) begin idle(); advN = 0; doCycle(tag); end
  endtask

  task automatic flush();
    idle(); ctlStrobeN = 0; selB = 0; doCycle("");
    idle(); doCycle(""); idle(); doCycle("");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mdlReset();
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, rdValid}, 32'h0);
    check("R1 reset data", rdData, 32'h0);
    rstN = 1;
    ctlCmd(6'd17, 1, 1, 4'hF, 0, "R1");          // cleared array reads 0
    idle(); doCycle("R1");

    for (int a = 0; a < DEPTH; a++)              // distinct contents
      ctlCmd(a[AW-1:0], 0, 1, 4'hF, 32'hA500_0000 | (a * 32'h0001_0203), "R5");
    ctlCmd(6'd8, 0, 0, 4'hE, 32'hAABB_CCDD, "R5"); // global overrides lanes
    ctlCmd(6'd8, 1, 0, 4'hA, 32'h1122_3344, "R5"); // lanes 0 and 2 only
    ctlCmd(6'd8, 1, 1, 4'hF, 0, "R5");
    idle(); doCycle("R5");

    idle(); cpuStrobeN = 0; addrIn = 6'd9; globalWrN = 0; wrData = 32'hDEAD_BEEF;
    doCycle("R3");                               // write inputs ignored
    ctlCmd(6'd9, 1, 1, 4'hF, 0, "R3");

    burstLinear = 1; burstRead(6'd6, "R7");      // 6,7,4,5,6
    burstLinear = 0; burstRead(6'd13, "R7");     // 13,12,15,14,13
    idle(); advN = 0; cpuStrobeN = 0; selAN = 1; doCycle("R3"); // masked strobe continues
    idle(); ctlStrobeN = 0; cpuStrobeN = 0; addrIn = 6'd20; doCycle("R3");
    idle(); advN = 1; doCycle("R6");             // suspend repeats address

    flush();
    idle(); advN = 0; globalWrN = 0; wrData = 32'h0BAD_0BAD; doCycle("R8");
    idle(); advN = 1; doCycle("R8");
    ctlCmd(6'd1, 1, 1, 4'hF, 0, "R8");

    idle(); sleep = 1; ctlStrobeN = 0; addrIn = 6'd3; globalWrN = 0; wrData = 32'hFFFF_FFFF;
    doCycle("R9");
    ctlCmd(6'd3, 1, 1, 4'hF, 0, "R9");
    idle(); advN = 0; doCycle("R6");
    idle(); sleep = 1; advN = 0; doCycle("R9");  // sleep ends the burst
    idle(); advN = 0; doCycle("R9");

    pipeMode = 1; idle(); doCycle(""); idle(); doCycle("");
    ctlCmd(6'd8, 1, 1, 4'hF, 0, "R10");
    ctlCmd(6'd9, 0, 1, 4'hF, 32'h7777_1111, "R10");
    ctlCmd(6'd9, 1, 1, 4'hF, 0, "R10");
    idle(); doCycle("R10"); idle(); doCycle("R10");

    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) begin pipeMode = 0; idle(); doCycle(""); end
      selAN = ($urandom % 8) == 0;
      selB  = ($urandom % 8) != 0;
      selCN = ($urandom % 8) == 0;
      cpuStrobeN = ($urandom % 6) != 0;
      ctlStrobeN = ($urandom % 4) != 0;
      advN = ($urandom % 3) == 0;
      globalWrN = ($urandom % 5) != 0;
      byteWrN = ($urandom % 2) != 0;
      laneWrN = 4'($urandom);
      burstLinear = ($urandom % 2) != 0;
      sleep = ($urandom % 20) == 0;
      addrIn = AW'($urandom);
      wrData = $urandom;
      doCycle("");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule